// File: doc/BRIEF.md
# Audio Transmit Sample Queue

This block is the transmit sample queue that sits between a bus or DMA engine and the serializer of a PCM audio port. Words written on the fill side are held in a 32-entry first-in first-out store and handed out, oldest first, to the serializer on the drain side. An occupancy count tracks how many words are held.

One programmable 6-bit level sets both watermarks. The low watermark flag is raised while occupancy is below the level. The high watermark flag is raised while occupancy is above the depth minus the level. A level of zero disables both watermarks. The DMA request stays high, when DMA is enabled, until the high watermark is reached. A level of at least 2 leaves room for one more word that a DMA engine may write after the request drops. The block raises a warning when DMA is enabled with a level under 2. All flags are registered and trail the occupancy count by one cycle, so software can poll them in place of interrupts.

Writes into a full queue are dropped, and reads from an empty queue return zero. Each of these raises a sticky error bit that stays set until a clear pulse. A synchronous flush empties the queue and keeps the programmed level.

Top module: `pcm_txq`

## Requirements
- R1: Words read out come in the order they were written, for up to 32 held words. Read data is registered and is valid on the cycle after `rd_en` is accepted.
- R2: A write and a read accepted in the same cycle leave `count` unchanged, and the count never exceeds 32.
- R3: A write while `count` is 32 and no read is accepted is dropped. `count` stays at 32, the dropped word never appears at the output, and `overflow` goes to 1 and stays there.
- R4: A read while `count` is 0 returns 0 on `rd_data` and sets the sticky `underflow` bit.
- R5: A one-cycle `sticky_clr` pulse clears both `overflow` and `underflow`.
- R6: `full` is 1 exactly when the count on the previous cycle was 32. `empty` is 1 exactly when the count on the previous cycle was 0.
- R7: `almost_empty` is 1 one cycle after a cycle in which the level was nonzero and the count was strictly below it.
- R8: `almost_full` is 1 one cycle after a cycle in which the level was nonzero and the count was strictly above 32 minus the level. Levels above 32 are handled without wraparound, so the flag stays asserted.
- R9: While the level is 0, `almost_full` and `almost_empty` are both held at 0 at every count.
- R10: `dma_req` equals the previous cycle's `dma_en` ANDed with the negation of the current `almost_full`.
- R11: `thresh_bad` is 1 one cycle after `dma_en` was 1 with a level below 2, and is 0 otherwise.
- R12: `flush` sets the count to 0 and resets the pointers without changing the level. The flags follow one cycle later.
- R13: After reset, `count` is 0, the level is 0, `empty` is 1, and every other flag, request and error bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty; keeps the level |
| sticky_clr | input | 1 | Clears overflow and underflow |
| thresh_wr | input | 1 | Loads `thresh_in` into the level register |
| thresh_in | input | 6 | New watermark level |
| dma_en | input | 1 | Enables the DMA request and the level check |
| wr_en | input | 1 | Write strobe from the bus or DMA |
| wr_data | input | 32 | Word to enqueue |
| rd_en | input | 1 | Read strobe from the serializer |
| rd_data | output | 32 | Dequeued word, registered; 0 on an empty read |
| thresh | output | 6 | Current watermark level |
| count | output | 6 | Occupancy, 0 to 32 |
| full | output | 1 | Registered full flag |
| empty | output | 1 | Registered empty flag |
| almost_full | output | 1 | Registered high-watermark flag |
| almost_empty | output | 1 | Registered low-watermark flag |
| dma_req | output | 1 | DMA request |
| thresh_bad | output | 1 | DMA enabled with a level below 2 |
| overflow | output | 1 | Sticky dropped-write bit |
| underflow | output | 1 | Sticky empty-read bit |

## Verification
The bench walks the count from 1 to 32 with a level of 4 and checks the high watermark on both sides of its edge, at 28 and at 29. A design that compared with `>=`, or that sampled the flag in the same cycle as the count, fails there. A level of 40 drives the term 32 minus the level negative, and a design that subtracts in an unsigned field would clear `almost_full` at an empty count. A write into a full queue is checked to leave the count at 32 and to keep the extra word out of the drained sequence; a design that let the pointer wrap would overwrite the oldest word. The bench also covers a combined read and write, an empty read that must return zero, and a flush that must keep the level.

// File: rtl/pcm_txq_pkg.sv
package pcm_txq_pkg;

   // Registered status bundle driven by the flag stage
   typedef struct packed {
      logic full;
      logic empty;
      logic almost_full;
      logic almost_empty;
   } txq_flags_t;

   localparam txq_flags_t TXQ_FLAGS_RESET = '{full: 1'b0, empty: 1'b1,
                                             almost_full: 1'b0, almost_empty: 1'b0};

endpackage

// File: rtl/pcm_txq_store.sv
module pcm_txq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_ok,
   input  logic [AW-1:0]     wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_ptr,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] words [DEPTH];

   // One register per slot; each slot decodes its own write select
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      logic              sel;

      assign sel = wr_ok && (wr_ptr == AW'(i));

      always_ff @(posedge clk) begin
         if (sel) slot_q <= wr_data;
      end

      assign words[i] = slot_q;
   end

   assign rd_word = words[rd_ptr];

endmodule

// File: rtl/pcm_txq_ctrl.sv
module pcm_txq_ctrl #(
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          sticky_clr,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          wr_ok,
   output logic          rd_ok,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [CW-1:0] count,
   output logic          overflow,
   output logic          underflow
);

   logic at_full;
   logic at_empty;
   logic ovf_set;
   logic unf_set;
   logic [CW-1:0] count_nx;

   assign at_full  = (count == CW'(DEPTH));
   assign at_empty = (count == '0);

   // A read frees a slot in the same cycle, so a full queue still takes a write
   assign rd_ok   = rd_en && !at_empty && !flush;
   assign wr_ok   = wr_en && !flush && (!at_full || rd_ok);
   assign ovf_set = wr_en && !flush && !wr_ok;
   assign unf_set = rd_en && !flush && at_empty;

   always_comb begin
      count_nx = count;
      unique case ({wr_ok, rd_ok})
         2'b10:   count_nx = count + 1'b1;
         2'b01:   count_nx = count - 1'b1;
         default: count_nx = count;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         count <= count_nx;
      end
   end

   // Sticky error bits: a new event in the clear cycle wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         overflow  <= (overflow  && !sticky_clr) || ovf_set;
         underflow <= (underflow && !sticky_clr) || unf_set;
      end
   end

endmodule

// File: rtl/pcm_txq_flags.sv
module pcm_txq_flags
   import pcm_txq_pkg::*;
#(
   parameter int DEPTH       = 32,
   parameter int THR_W       = 6,
   parameter int MIN_DMA_THR = 2,
   localparam int CW         = $clog2(DEPTH + 1),
   localparam int SW         = ((CW > THR_W) ? CW : THR_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    count,
   input  logic [THR_W-1:0] thresh,
   input  logic             dma_en,
   output txq_flags_t       flags,
   output logic             dma_req,
   output logic             thresh_bad
);

   logic [SW-1:0] cnt_x;
   logic [SW-1:0] thr_x;
   logic          thr_on;
   logic          ae_c;
   logic          af_c;
   txq_flags_t    flags_c;

   assign cnt_x  = SW'(count);
   assign thr_x  = SW'(thresh);
   assign thr_on = (thresh != '0);

   // count > DEPTH - thr is rewritten as count + thr > DEPTH, so no term goes negative
   assign ae_c = thr_on && (cnt_x < thr_x);
   assign af_c = thr_on && ((cnt_x + thr_x) > SW'(DEPTH));

   always_comb begin
      flags_c.full         = (count == CW'(DEPTH));
      flags_c.empty        = (count == '0);
      flags_c.almost_full  = af_c;
      flags_c.almost_empty = ae_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags      <= TXQ_FLAGS_RESET;
         dma_req    <= 1'b0;
         thresh_bad <= 1'b0;
      end else begin
         flags      <= flags_c;
         dma_req    <= dma_en && !af_c;
         thresh_bad <= dma_en && (thr_x < SW'(MIN_DMA_THR));
      end
   end

endmodule

// File: rtl/pcm_txq.sv
module pcm_txq
   import pcm_txq_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 32,
   parameter int THR_W       = 6,
   parameter int MIN_DMA_THR = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              sticky_clr,
   input  logic              thresh_wr,
   input  logic [THR_W-1:0]  thresh_in,
   input  logic              dma_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [THR_W-1:0]  thresh,
   output logic [CW-1:0]     count,
   output logic              full,
   output logic              empty,
   output logic              almost_full,
   output logic              almost_empty,
   output logic              dma_req,
   output logic              thresh_bad,
   output logic              overflow,
   output logic              underflow
);

   // Elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_data_w
      $error("pcm_txq: DATA_W must be at least 1");
   end
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("pcm_txq: DEPTH must be a power of two, at least 2");
   end
   if (THR_W < CW) begin : g_bad_thr_w
      $error("pcm_txq: THR_W must be able to express DEPTH");
   end
   if ((MIN_DMA_THR < 1) || (MIN_DMA_THR > DEPTH)) begin : g_bad_min_thr
      $error("pcm_txq: MIN_DMA_THR out of range");
   end

   logic          wr_ok;
   logic          rd_ok;
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic [DATA_W-1:0] rd_word;
   txq_flags_t    flags;

   // Watermark level register; flush leaves it alone
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thresh <= '0;
      else if (thresh_wr) thresh <= thresh_in;
   end

   pcm_txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .sticky_clr (sticky_clr),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .wr_ok      (wr_ok),
      .rd_ok      (rd_ok),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr),
      .count      (count),
      .overflow   (overflow),
      .underflow  (underflow)
   );

   pcm_txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_ok   (wr_ok),
      .wr_ptr  (wr_ptr),
      .wr_data (wr_data),
      .rd_ptr  (rd_ptr),
      .rd_word (rd_word)
   );

   pcm_txq_flags #(
      .DEPTH       (DEPTH),
      .THR_W       (THR_W),
      .MIN_DMA_THR (MIN_DMA_THR)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .count      (count),
      .thresh     (thresh),
      .dma_en     (dma_en),
      .flags      (flags),
      .dma_req    (dma_req),
      .thresh_bad (thresh_bad)
   );

   // Registered read port: an empty read yields zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rd_data <= '0;
      else if (rd_en && !flush)  rd_data <= rd_ok ? rd_word : '0;
   end

   assign full         = flags.full;
   assign empty        = flags.empty;
   assign almost_full  = flags.almost_full;
   assign almost_empty = flags.almost_empty;

endmodule

// File: rtl/pcm_txq_chk.sv
module pcm_txq_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int THR_W  = 6,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              sticky_clr,
   input logic              thresh_wr,
   input logic              dma_en,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [THR_W-1:0]  thresh,
   input logic [CW-1:0]     count,
   input logic              full,
   input logic              empty,
   input logic              almost_full,
   input logic              almost_empty,
   input logic              dma_req,
   input logic              thresh_bad,
   input logic              overflow,
   input logic              underflow
);

   assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH) && wr_en && !rd_en && !flush) |=> (count == CW'(DEPTH) && overflow));

   assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && rd_en && !flush) |=> (underflow && rd_data == '0));

   assert_sticky_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_clr && !wr_en && !rd_en) |=> (!overflow && !underflow));

   assert_full_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (full == $past(count == CW'(DEPTH)) && empty == $past(count == '0)));

   assert_low_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (almost_empty == $past(thresh != '0 && (count < CW'(thresh)))));

   assert_zero_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh == '0) |=> (!almost_full && !almost_empty));

   assert_dma_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (dma_req == ($past(dma_en) && !almost_full)));

   assert_level_warn_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (thresh_bad == ($past(dma_en) && ($past(thresh) < THR_W'(2)))));

   assert_flush_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !thresh_wr) |=> (count == '0 && thresh == $past(thresh)));

endmodule

bind pcm_txq pcm_txq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .sticky_clr   (sticky_clr),
   .thresh_wr    (thresh_wr),
   .dma_en       (dma_en),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .rd_data      (rd_data),
   .thresh       (thresh),
   .count        (count),
   .full         (full),
   .empty        (empty),
   .almost_full  (almost_full),
   .almost_empty (almost_empty),
   .dma_req      (dma_req),
   .thresh_bad   (thresh_bad),
   .overflow     (overflow),
   .underflow    (underflow)
);

// File: tb/pcm_txq_tb.sv
module pcm_txq_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        flush, sticky_clr, thresh_wr, dma_en, wr_en, rd_en;
   logic [5:0]  thresh_in;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic [5:0]  thresh;
   logic [5:0]  count;
   logic        full, empty, almost_full, almost_empty, dma_req, thresh_bad;
   logic        overflow, underflow;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_txq u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .sticky_clr(sticky_clr),
      .thresh_wr(thresh_wr), .thresh_in(thresh_in), .dma_en(dma_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .thresh(thresh), .count(count), .full(full), .empty(empty),
      .almost_full(almost_full), .almost_empty(almost_empty),
      .dma_req(dma_req), .thresh_bad(thresh_bad),
      .overflow(overflow), .underflow(underflow)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic push(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic pop();
      rd_en = 1'b1;
      step();
      rd_en = 1'b0;
   endtask

   task automatic set_level(input int v);
      thresh_wr = 1'b1; thresh_in = 6'(v);
      step();
      thresh_wr = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      step();
      flush = 1'b0;
   endtask

   task automatic t_reset();
      chk("R13", "count", count, 0);
      chk("R13", "thresh", thresh, 0);
      chk("R13", "empty", empty, 1);
      chk("R13", "full", full, 0);
      chk("R13", "almost_full", almost_full, 0);
      chk("R13", "almost_empty", almost_empty, 0);
      chk("R13", "dma_req", dma_req, 0);
      chk("R13", "overflow", overflow, 0);
      chk("R13", "underflow", underflow, 0);
      chk("R13", "rd_data", rd_data, 0);
   endtask

   // Fill to 32 with level 4 and DMA enabled; check flags after each word
   task automatic t_fill_marks();
      set_level(4);
      dma_en = 1'b1;
      step(); step();
      chk("R7", "almost_empty at 0", almost_empty, 1);
      chk("R10", "dma_req at 0", dma_req, 1);
      for (int k = 1; k <= 32; k++) begin
         push(32'hA500_0000 + 32'(k));
         chk("R2", "count after push", count, k);
         step();
         chk("R7", "almost_empty", almost_empty, (k < 4) ? 1 : 0);
         chk("R8", "almost_full", almost_full, (k > 28) ? 1 : 0);
         chk("R10", "dma_req", dma_req, (k > 28) ? 0 : 1);
         chk("R6", "full", full, (k == 32) ? 1 : 0);
         chk("R6", "empty", empty, 0);
      end
   endtask

   task automatic t_overflow();
      push(32'hDEAD_BEEF);
      chk("R3", "count held at 32", count, 32);
      chk("R3", "overflow set", overflow, 1);
      step();
      chk("R3", "overflow sticky", overflow, 1);
   endtask

   task automatic t_zero_level_full();
      set_level(0);
      step(); step();
      chk("R9", "almost_full at level 0, count 32", almost_full, 0);
      chk("R9", "almost_empty at level 0", almost_empty, 0);
      chk("R10", "dma_req at level 0", dma_req, 1);
      dma_en = 1'b0;
      step(); step();
      chk("R10", "dma_req with dma_en low", dma_req, 0);
   endtask

   task automatic t_drain();
      for (int k = 1; k <= 32; k++) begin
         pop();
         chk("R1", "rd_data order", rd_data, 32'hA500_0000 + 32'(k));
      end
      chk("R1", "count after drain", count, 0);
      step();
      chk("R6", "empty after drain", empty, 1);
      chk("R6", "full after drain", full, 0);
   endtask

   task automatic t_underflow_clear();
      pop();
      chk("R4", "rd_data on empty read", rd_data, 0);
      chk("R4", "underflow", underflow, 1);
      chk("R4", "count stays 0", count, 0);
      sticky_clr = 1'b1;
      step();
      sticky_clr = 1'b0;
      chk("R5", "overflow cleared", overflow, 0);
      chk("R5", "underflow cleared", underflow, 0);
   endtask

   task automatic t_simul();
      push(32'hB000_0000);
      push(32'hB000_0001);
      push(32'hB000_0002);
      wr_en = 1'b1; rd_en = 1'b1; wr_data = 32'hB000_0003;
      step();
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R2", "count on read+write", count, 3);
      chk("R1", "rd_data on read+write", rd_data, 32'hB000_0000);
      for (int k = 1; k <= 3; k++) begin
         pop();
         chk("R1", "rd_data after read+write", rd_data, 32'hB000_0000 + 32'(k));
      end
   endtask

   task automatic t_level_warn();
      dma_en = 1'b1;
      set_level(1);
      step();
      chk("R11", "thresh_bad level 1", thresh_bad, 1);
      set_level(2);
      step();
      chk("R11", "thresh_bad level 2", thresh_bad, 0);
      dma_en = 1'b0;
      set_level(0);
      step();
      chk("R11", "thresh_bad dma off", thresh_bad, 0);
   endtask

   task automatic t_big_level();
      set_level(40);
      step();
      chk("R8", "almost_full level 40 count 0", almost_full, 1);
      chk("R7", "almost_empty level 40 count 0", almost_empty, 1);
   endtask

   task automatic t_flush();
      set_level(4);
      push(32'hC000_0000);
      push(32'hC000_0001);
      step();
      chk("R12", "count before flush", count, 2);
      do_flush();
      chk("R12", "count after flush", count, 0);
      chk("R12", "level kept", thresh, 4);
      step();
      chk("R12", "empty after flush", empty, 1);
      chk("R12", "almost_empty after flush", almost_empty, 1);
      push(32'hC000_0002);
      pop();
      chk("R12", "data after flush", rd_data, 32'hC000_0002);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; flush = 1'b0; sticky_clr = 1'b0; thresh_wr = 1'b0;
      dma_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; thresh_in = '0; wr_data = '0;
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_fill_marks();
      t_overflow();
      t_zero_level_full();
      t_drain();
      t_underflow_clear();
      t_simul();
      t_level_warn();
      t_big_level();
      t_flush();
      step();
      finish_run();
   end

endmodule